// File: doc/BRIEF.md
# YCbCr to RGB Colour Matrix

This block converts a stream of YCbCr pixels for a display plane into 10-bit RGB. Chroma arrives signed, so no offset is needed to centre it. Each of the three input channels first gets its own programmable offset and is then clamped to its own programmable limits. A 3x3 matrix of signed fixed-point coefficients follows, in which 4096 means a gain of one. The matrix sums are rounded and scaled back. Each output channel then gets its own offset and is clamped to its own limits. Range expansion is done upstream of this block.

Software loads coefficients, offsets and limits through a plain write port (enable, word address, 32-bit data); there is no read path. Pixels enter and leave on valid/ready handshakes. A pixel is transferred on a cycle where valid and ready are both high. A producer that raises `in_valid` keeps the pixel stable until it is taken. When the consumer holds `out_ready` low with `out_valid` high, the whole two-stage pipeline freezes and the output pixel stays unchanged. A pixel flagged as RGB is not sent through the arithmetic. It travels through the same two registers, so the order of pixels never changes. Registers should be written only while no pixel is in flight.

Top module: `csc_ycbcr2rgb`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high even with `out_ready` low. The registers then hold the full-range BT.601 set: rows R=(5743,4096,0), G=(-2925,4096,-1410), B=(0,4096,7258) over the columns (Cr,Y,Cb), all offsets 0, Y input clamp 0..1023, Cr/Cb input clamp -512..512, and output clamps 0..1023.
- R2: Input channel c is `in_ch0`=Cr, `in_ch1`=Y or `in_ch2`=Cb. It becomes clamp(x + ioff[c], imin[c], imax[c]). The offset is written at address 5+c in data bits [10:0]. The clamp limits are written at address 8+c, with the minimum in bits [10:0] and the maximum in bits [26:16]. All of these values are 11-bit two's complement.
- R3: Output row r (R=0, G=1, B=2) sums coef[3r+c] times clamped input c. Each coefficient is 16-bit two's complement. Register k (0..4) holds coef[2k] in bits [15:0] and coef[2k+1] in bits [31:16]; the upper half of register 4 is unused.
- R4: The full-precision sum has 2048 added to it and is then arithmetically shifted right by 12.
- R5: The rounded value of row r has ooff[r] added to it and is clamped to omin[r]..omax[r]. The offset is at address 11+r in bits [10:0]. The limits are at address 14+r, with the minimum in bits [10:0] and the maximum in bits [26:16]. The output is the low 10 bits of the result.
- R6: A pixel accepted with `in_rgb` high leaves with R, G and B equal to the low 10 bits of `in_ch0`, `in_ch1` and `in_ch2`.
- R7: With `out_ready` held high, a pixel accepted at clock edge n appears on the output after edge n+1. Pixels leave in the order they were accepted, whether bypassed or converted.
- R8: `in_ready` equals `out_ready` OR NOT `out_valid`. While `out_valid` is high and `out_ready` is low, the output pixel holds its value.
- R9: Writes to addresses 17 and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high |
| in_rgb | input | 1 | Pixel is already RGB; bypass the matrix |
| in_ch0 | input | 11 | Cr (or R), two's complement |
| in_ch1 | input | 11 | Y (or G), two's complement |
| in_ch2 | input | 11 | Cb (or B), two's complement |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_r | output | 10 | Red |
| out_g | output | 10 | Green |
| out_b | output | 10 | Blue |

## Verification
The case hardest to reach from the ports is the rounding boundary. An accumulated sum that is exactly half a unit, or just below it on the negative side, appears only with deliberately chosen coefficients. The stimulus writes a matrix of ±2048 and -2049 coefficients, feeds small luma values through it, and adds an output offset so that a result of -1 becomes visible above the zero clamp. A second hard case is a stall that lands while a bypassed pixel and a converted pixel sit in adjacent stages. The stimulus mixes both kinds and holds `out_ready` low on every third cycle.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NCH       = 3;
  localparam int NCOEF     = NCH * NCH;
  localparam int NCOEF_REG = (NCOEF + 1) / 2;
  localparam int A_IOFF    = NCOEF_REG;
  localparam int A_ICLMP   = A_IOFF + NCH;
  localparam int A_OOFF    = A_ICLMP + NCH;
  localparam int A_OCLMP   = A_OOFF + NCH;

  // full-range BT.601, rows R,G,B over columns Cr,Y,Cb
  function automatic int bt601_coef(int idx);
    case (idx)
      0: return 5743;
      1: return 4096;
      3: return -2925;
      4: return 4096;
      5: return -1410;
      7: return 4096;
      8: return 7258;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
#(
  parameter int IW = 11,
  parameter int OW = 10,
  parameter int CW = 16,
  parameter int AW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [31:0]                wdata,
  output logic [NCOEF-1:0][CW-1:0]   coef,
  output logic [NCH-1:0][IW-1:0]     ioff,
  output logic [NCH-1:0][IW-1:0]     imin,
  output logic [NCH-1:0][IW-1:0]     imax,
  output logic [NCH-1:0][IW-1:0]     ooff,
  output logic [NCH-1:0][IW-1:0]     omin,
  output logic [NCH-1:0][IW-1:0]     omax
);
  localparam int HALF  = 1 << (OW - 1);
  localparam int FULL  = (1 << OW) - 1;
  localparam int YCH   = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCOEF; k++) coef[k] <= CW'(bt601_coef(k));
      for (int c = 0; c < NCH; c++) begin
        ioff[c] <= '0;
        ooff[c] <= '0;
        imin[c] <= (c == YCH) ? IW'(0)    : IW'(-HALF);
        imax[c] <= (c == YCH) ? IW'(FULL) : IW'(HALF);
        omin[c] <= '0;
        omax[c] <= IW'(FULL);
      end
    end else if (wr_en) begin
      for (int k = 0; k < NCOEF; k++)
        if (addr == AW'(k / 2))
          coef[k] <= (k % 2 == 0) ? wdata[CW-1:0] : wdata[16 +: CW];
      for (int c = 0; c < NCH; c++) begin
        if (addr == AW'(A_IOFF + c))  ioff[c] <= wdata[IW-1:0];
        if (addr == AW'(A_ICLMP + c)) begin
          imin[c] <= wdata[IW-1:0];
          imax[c] <= wdata[16 +: IW];
        end
        if (addr == AW'(A_OOFF + c))  ooff[c] <= wdata[IW-1:0];
        if (addr == AW'(A_OCLMP + c)) begin
          omin[c] <= wdata[IW-1:0];
          omax[c] <= wdata[16 +: IW];
        end
      end
    end
  end
endmodule

// File: rtl/csc_in_stage.sv
module csc_in_stage
  import csc_pkg::*;
#(
  parameter int IW = 11,
  parameter int OW = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic [NCH-1:0][IW-1:0] x,
  input  logic [NCH-1:0][IW-1:0] ioff,
  input  logic [NCH-1:0][IW-1:0] imin,
  input  logic [NCH-1:0][IW-1:0] imax,
  output logic [NCH-1:0][IW-1:0] xc,
  output logic [NCH-1:0][OW-1:0] raw
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [IW:0]   sum, mn, mx;
    logic signed [IW-1:0] cl;

    always_comb begin
      sum = (IW+1)'($signed(x[c])) + (IW+1)'($signed(ioff[c]));
      mn  = (IW+1)'($signed(imin[c]));
      mx  = (IW+1)'($signed(imax[c]));
      if (sum < mn)      cl = mn[IW-1:0];
      else if (sum > mx) cl = mx[IW-1:0];
      else               cl = sum[IW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xc[c]  <= '0;
        raw[c] <= '0;
      end else if (adv) begin
        xc[c]  <= cl;
        raw[c] <= x[c][OW-1:0];
      end
    end

    AST_IN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (mn <= mx) |-> ((IW+1)'(cl) >= mn && (IW+1)'(cl) <= mx)); // R2
  end
endmodule

// File: rtl/csc_mac.sv
module csc_mac
  import csc_pkg::*;
#(
  parameter int IW   = 11,
  parameter int OW   = 10,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     rgb,
  input  logic [NCH-1:0][IW-1:0]   xc,
  input  logic [NCH-1:0][OW-1:0]   raw,
  input  logic [NCOEF-1:0][CW-1:0] coef,
  input  logic [NCH-1:0][IW-1:0]   ooff,
  input  logic [NCH-1:0][IW-1:0]   omin,
  input  logic [NCH-1:0][IW-1:0]   omax,
  output logic [NCH-1:0][OW-1:0]   y
);
  localparam int SW  = IW + CW + 2;
  localparam int RND = 1 << (FRAC - 1);

  for (genvar r = 0; r < NCH; r++) begin : g_row
    logic signed [SW-1:0] acc, ce, xe, rnd, shf, ofs, mn, mx, cl;

    always_comb begin
      acc = '0;
      for (int c = 0; c < NCH; c++) begin
        ce  = SW'($signed(coef[r*NCH + c]));
        xe  = SW'($signed(xc[c]));
        acc = acc + ce * xe;
      end
      rnd = acc + SW'(RND);
      shf = rnd >>> FRAC;
      ofs = shf + SW'($signed(ooff[r]));
      mn  = SW'($signed(omin[r]));
      mx  = SW'($signed(omax[r]));
      if (ofs < mn)      cl = mn;
      else if (ofs > mx) cl = mx;
      else               cl = ofs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   y[r] <= '0;
      else if (adv) y[r] <= rgb ? raw[r] : cl[OW-1:0];
    end

    AST_OUT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (mn <= mx) |-> (cl >= mn && cl <= mx)); // R5
  end
endmodule

// File: rtl/csc_ycbcr2rgb.sv
module csc_ycbcr2rgb
  import csc_pkg::*;
#(
  parameter int IW   = 11,
  parameter int OW   = 10,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int AW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [31:0]          cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_rgb,
  input  logic signed [IW-1:0] in_ch0,
  input  logic signed [IW-1:0] in_ch1,
  input  logic signed [IW-1:0] in_ch2,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OW-1:0]        out_r,
  output logic [OW-1:0]        out_g,
  output logic [OW-1:0]        out_b
);
  logic [NCOEF-1:0][CW-1:0] coef;
  logic [NCH-1:0][IW-1:0]   ioff, imin, imax, ooff, omin, omax, xc;
  logic [NCH-1:0][OW-1:0]   raw, y;
  logic                     adv, s1_valid, s1_rgb;

  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  csc_regs #(.IW(IW), .OW(OW), .CW(CW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .coef(coef), .ioff(ioff), .imin(imin),
    .imax(imax), .ooff(ooff), .omin(omin), .omax(omax)
  );

  csc_in_stage #(.IW(IW), .OW(OW)) in_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .x({in_ch2, in_ch1, in_ch0}), .ioff(ioff), .imin(imin),
    .imax(imax), .xc(xc), .raw(raw)
  );

  csc_mac #(.IW(IW), .OW(OW), .CW(CW), .FRAC(FRAC)) mac_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .rgb(s1_rgb), .xc(xc),
    .raw(raw), .coef(coef), .ooff(ooff), .omin(omin), .omax(omax),
    .y(y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_rgb    <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      s1_rgb    <= in_rgb;
      out_valid <= s1_valid;
    end
  end

  assign out_r = y[0];
  assign out_g = y[1];
  assign out_b = y[2];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r)
      && $stable(out_g) && $stable(out_b))); // R8
  AST_FILL_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid); // R7
  AST_FILL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && in_ready) |=> out_valid); // R7
endmodule

// File: tb/csc_ycbcr2rgb_tb_top.sv
module csc_ycbcr2rgb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_rgb = 1'b0, out_ready = 1'b1;
  logic signed [10:0] in_ch0 = '0, in_ch1 = '0, in_ch2 = '0;
  logic in_ready, out_valid;
  logic [9:0] out_r, out_g, out_b;

  always #5 clk = ~clk;

  csc_ycbcr2rgb dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_rgb(in_rgb), .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
    .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r),
    .out_g(out_g), .out_b(out_b)
  );

  int n_chk = 0, n_bad = 0, tick_n = 0;
  bit stress = 1'b0, last_acc = 1'b0;
  string cur_tag = "R1";
  logic [29:0] q_exp[$];
  string q_tag[$];
  int m_coef[9];
  int m_ioff[3], m_imin[3], m_imax[3], m_ooff[3], m_omin[3], m_omax[3];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sx(logic [31:0] v, int w);
    int t;
    t = v << (32 - w);
    return t >>> (32 - w);
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [29:0] model(bit rgb, int a0, int a1, int a2);
    int x[3], xc[3], res[3], acc;
    x[0] = a0; x[1] = a1; x[2] = a2;
    if (rgb) begin
      for (int c = 0; c < 3; c++) res[c] = x[c] & 1023;
    end else begin
      for (int c = 0; c < 3; c++)
        xc[c] = clampi(x[c] + m_ioff[c], m_imin[c], m_imax[c]);
      for (int r = 0; r < 3; r++) begin
        acc = 0;
        for (int c = 0; c < 3; c++) acc += m_coef[r*3+c] * xc[c];
        acc = ((acc + 2048) >>> 12) + m_ooff[r];
        res[r] = clampi(acc, m_omin[r], m_omax[r]) & 1023;
      end
    end
    return {res[0][9:0], res[1][9:0], res[2][9:0]};
  endfunction

  task automatic eval_tick();
    logic [29:0] got;
    int a0, a1, a2;
    last_acc = 1'b0;
    chk(in_ready === (out_ready || !out_valid), "R8", int'(in_ready),
        int'(out_ready || !out_valid));
    if (out_valid === 1'b1) begin
      got = {out_r, out_g, out_b};
      if (q_exp.size() == 0) chk(1'b0, "R7", int'(got), 0);
      else begin
        chk(got === q_exp[0], q_tag[0], int'(got), int'(q_exp[0]));
        if (out_ready) begin
          void'(q_exp.pop_front());
          void'(q_tag.pop_front());
        end
      end
    end
    if (in_valid && in_ready) begin
      a0 = in_ch0; a1 = in_ch1; a2 = in_ch2;
      q_exp.push_back(model(in_rgb, a0, a1, a2));
      q_tag.push_back(in_rgb ? "R6" : cur_tag);
      last_acc = 1'b1;
    end
  endtask

  task automatic drive(bit v, bit rgb, int c0, int c1, int c2);
    @(negedge clk);
    tick_n++;
    cfg_wr_en = 1'b0;
    in_valid = v; in_rgb = rgb;
    in_ch0 = 11'(c0); in_ch1 = 11'(c1); in_ch2 = 11'(c2);
    out_ready = stress ? (tick_n % 3 != 2) : 1'b1;
    #1 eval_tick();
  endtask

  task automatic send(bit rgb, int c0, int c1, int c2);
    do drive(1'b1, rgb, c0, c1, c2); while (!last_acc);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && (q_exp.size() != 0 || out_valid); i++)
      drive(1'b0, 1'b0, 0, 0, 0);
  endtask

  task automatic cfg_write(int addr, logic [31:0] d);
    @(negedge clk);
    tick_n++;
    in_valid = 1'b0; out_ready = 1'b1;
    cfg_wr_en = 1'b1; cfg_addr = 5'(addr); cfg_wdata = d;
    #1 eval_tick();
    if (addr < 5) begin
      m_coef[2*addr] = sx(d[15:0], 16);
      if (2*addr + 1 < 9) m_coef[2*addr+1] = sx(d[31:16], 16);
    end else if (addr < 8)  m_ioff[addr-5] = sx(d[10:0], 11);
    else if (addr < 11) begin
      m_imin[addr-8] = sx(d[10:0], 11); m_imax[addr-8] = sx(d[26:16], 11);
    end else if (addr < 14) m_ooff[addr-11] = sx(d[10:0], 11);
    else if (addr < 17) begin
      m_omin[addr-14] = sx(d[10:0], 11); m_omax[addr-14] = sx(d[26:16], 11);
    end
  endtask

  task automatic set_coef(int k, int v);
    int a;
    m_coef[k] = v;
    a = k / 2;
    if (2*a + 1 < 9) cfg_write(a, {16'(m_coef[2*a+1]), 16'(m_coef[2*a])});
    else             cfg_write(a, {16'h0, 16'(m_coef[2*a])});
  endtask

  task automatic set_lim(int addr, int mn, int mx);
    cfg_write(addr, {5'b0, 11'(mx), 5'b0, 11'(mn)});
  endtask

  task automatic set_off(int addr, int v);
    cfg_write(addr, {21'b0, 11'(v)});
  endtask

  task automatic set_bt601();
    int d[9] = '{5743, 4096, 0, -2925, 4096, -1410, 0, 4096, 7258};
    for (int k = 0; k < 9; k++) set_coef(k, d[k]);
  endtask

  initial begin
    int d[9] = '{5743, 4096, 0, -2925, 4096, -1410, 0, 4096, 7258};
    for (int k = 0; k < 9; k++) m_coef[k] = d[k];
    for (int c = 0; c < 3; c++) begin
      m_ioff[c] = 0; m_ooff[c] = 0; m_omin[c] = 0; m_omax[c] = 1023;
      m_imin[c] = (c == 1) ? 0 : -512;
      m_imax[c] = (c == 1) ? 1023 : 512;
    end
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1", int'(in_ready), 1);

    // R1 reset coefficient set
    cur_tag = "R1";
    send(0, 0, 512, 0);
    send(0, 100, 500, -200);
    send(0, -300, 800, 250);
    send(0, 700, 1023, -700);
    drain();

    // R3 matrix indexing and packing
    cur_tag = "R3";
    set_coef(0, 0); set_coef(1, 0); set_coef(2, 4096);
    set_coef(3, 0); set_coef(4, 2048); set_coef(5, 1024);
    set_coef(6, 4096); set_coef(7, -4096); set_coef(8, 0);
    send(0, 200, 300, 400);
    send(0, 500, 100, -100);
    drain();

    // R2 input offset and clamp, limited-range set
    cur_tag = "R2";
    set_bt601();
    set_off(6, -64);
    set_lim(9, 64, 940);
    set_lim(8, -448, 448);
    set_lim(10, -448, 448);
    send(0, 0, 30, 0);
    send(0, 0, 1000, 0);
    send(0, 600, 500, -600);
    send(0, -10, 300, 20);
    drain();

    // R4 rounding boundaries
    cur_tag = "R4";
    set_off(6, 0);
    set_lim(9, 0, 1023);
    for (int k = 0; k < 9; k++) set_coef(k, 0);
    set_coef(1, 2048); set_coef(4, -2048); set_coef(7, -2049);
    set_off(13, 5);
    send(0, 0, 1, 0);
    send(0, 0, 3, 0);
    send(0, 0, 2, 0);
    drain();

    // R5 output offset and clamp
    cur_tag = "R5";
    set_bt601();
    set_off(13, 0);
    set_off(12, 300);
    set_lim(14, 100, 900);
    send(0, 0, 20, 0);
    send(0, 400, 1000, 400);
    send(0, 0, 900, 0);
    send(0, -500, 50, -500);
    drain();

    // R9 unmapped addresses
    cur_tag = "R9";
    cfg_write(17, 32'hFFFF_FFFF);
    cfg_write(31, 32'h8000_8000);
    send(0, 100, 500, -200);
    send(0, 0, 20, 0);
    drain();

    // R7 latency
    cur_tag = "R7";
    drive(1'b1, 1'b0, 0, 512, 0);
    drive(1'b0, 1'b0, 0, 0, 0);
    chk(out_valid === 1'b0, "R7", int'(out_valid), 0);
    drive(1'b0, 1'b0, 0, 0, 0);
    chk(out_valid === 1'b1, "R7", int'(out_valid), 1);
    drain();

    // R6/R7/R8 mixed stream under back-pressure
    cur_tag = "R8";
    stress = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(i % 3 == 0, (i * 137) % 1024 - 512, (i * 61) % 1024,
           (i * 89) % 1024 - 512);
      if (i % 7 == 0) drive(1'b0, 1'b0, 0, 0, 0);
    end
    stress = 1'b0;
    drain();
    chk(q_exp.size() == 0, "R7", q_exp.size(), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule